// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog that cannot be switched off. A counter advances on every machine-cycle tick. Software must service it before it reaches its top value. If it does not, the block raises an internal reset request. That request is held for a programmable number of clock cycles. The counter then starts again from zero. The request goes only to on-chip reset logic and never to an external reset pin.

Servicing is done through a write-only byte register. A service takes effect only when the byte 0x1E is written and the next write to that register carries 0xE1. Any other pattern of writes leaves the count untouched. Cycles in which nothing is written may fall between the two key bytes.

The block keeps counting while the processor idles. In power-down it freezes its count and holds it.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_n` is low the count is zero and `rst_req` is low. After reset, the count rises by one on each clock edge at which `mc_tick` is high and `pdown_mode` is low.
- R2: A write of 0x1E followed by a next write of 0xE1 clears the count at the edge of the 0xE1 write. With `mc_tick` held high, `rst_req` then rises exactly 2^CNT_W edges after that edge.
- R3: When the count holds its top value (all ones, 0x3FFF by default), the next edge raises `rst_req` and clears the count. With `mc_tick` held high from reset release and no service, `rst_req` rises at the 2^CNT_W-th edge.
- R4: Broken key patterns leave the count unchanged. These are: 0xE1 with no 0x1E as the previous write, and 0x1E followed by any other byte and then 0xE1. No write value can stop the counter. A repeated 0x1E keeps the sequence armed, and clock cycles with no write between the two key bytes do not break it.
- R5: `idle_mode` has no effect on counting. Each edge with `pdown_mode` high leaves the count frozen, so the expiry is delayed by exactly that many edges.
- R6: An edge with `mc_tick` low does not advance the count, so the expiry is delayed by exactly that many edges.
- R7: `rst_req` stays high for exactly RST_LEN clock cycles. While it is high, the count is held at zero and writes are ignored, including a 0x1E that would arm the sequence. After it falls, the next expiry comes 2^CNT_W ticking edges after the edge where it fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | Machine-cycle enable; one count per high edge |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Byte written to the service register |
| idle_mode | input | 1 | Processor idle flag (counting continues) |
| pdown_mode | input | 1 | Power-down flag (count frozen) |
| rst_req | output | 1 | Internal reset request pulse, RST_LEN cycles long |

## Verification
The assertions check several properties on every cycle:
- each ticking edge advances the count by exactly one;
- power-down holds the count stable;
- a completed key clears the count;
- an all-ones count is always followed by a reset request, during which the count stays at zero;
- the armed state can only begin after a 0x1E write.

Some properties only the bench scenarios can show, because they are end-to-end timings measured at the pins. These are the exact number of edges from reset, service or pulse end to the next request. They also include the exact pulse length, and the harmlessness of broken or mistimed key patterns and of writes made during the pulse.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;
  localparam logic [7:0] SVC_KEY_FIRST  = 8'h1E;
  localparam logic [7:0] SVC_KEY_SECOND = 8'hE1;

  typedef enum logic {
    KEY_WAIT  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_t;

  function automatic logic is_byte(input logic [7:0] d, input logic [7:0] k);
    return d == k;
  endfunction
endpackage

// File: rtl/svc_wdog_keyseq.sv
module svc_wdog_keyseq
  import svc_wdog_pkg::*;
#(
  parameter logic [7:0] KEY_A = SVC_KEY_FIRST,
  parameter logic [7:0] KEY_B = SVC_KEY_SECOND
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       block,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       kick
);
  key_state_t state_q;
  logic       wr_live;
  logic       saw_first;
  logic       saw_second;

  assign wr_live    = wr_en && !block;
  assign saw_first  = is_byte(wr_data, KEY_A);
  assign saw_second = is_byte(wr_data, KEY_B);
  assign kick       = wr_live && saw_second && (state_q == KEY_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= KEY_WAIT;
    else if (block)
      state_q <= KEY_WAIT;
    else if (wr_live)
      state_q <= saw_first ? KEY_ARMED : KEY_WAIT;
  end

  AST_ARM_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == KEY_ARMED) |-> $past(wr_en && wr_data == KEY_A && !block)); // R2

  AST_BLOCK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> state_q == KEY_WAIT); // R7
endmodule

// File: rtl/svc_wdog_count.sv
module svc_wdog_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pdown,
  input  logic             kick,
  input  logic             hold,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic advance;
  assign advance = tick && !pdown;
  assign expire  = (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (hold || expire || kick)
      count <= '0;
    else if (advance)
      count <= step(count);
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pdown && !kick && !hold && count != TOP) |=> count == $past(count) + 1'b1); // R1

  AST_PDOWN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !kick && !hold && count != TOP) |=> $stable(count)); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kick && !hold && count != TOP) |=> $stable(count)); // R6

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> count == '0); // R2
endmodule

// File: rtl/svc_wdog_pulse.sv
module svc_wdog_pulse #(
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(RST_LEN);

  logic [PW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (fire && !active)
      left_q <= LOAD;
    else if (active)
      left_q <= left_q - 1'b1;
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !active) |=> active); // R3

  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> left_q == LOAD); // R7
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdog_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int RST_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       idle_mode,
  input  logic       pdown_mode,
  output logic       rst_req
);
  logic             kick;
  logic             expire;
  logic [CNT_W-1:0] count;
  logic             idle_seen;

  assign idle_seen = idle_mode;

  svc_wdog_keyseq #(
    .KEY_A(SVC_KEY_FIRST),
    .KEY_B(SVC_KEY_SECOND)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .block  (rst_req),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .kick   (kick)
  );

  svc_wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (mc_tick),
    .pdown (pdown_mode),
    .kick  (kick),
    .hold  (rst_req),
    .expire(expire),
    .count (count)
  );

  svc_wdog_pulse #(.RST_LEN(RST_LEN)) u_pls (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (expire),
    .active(rst_req)
  );

  AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rst_req); // R3

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> count == '0); // R7

  AST_IDLE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_seen && mc_tick && !pdown_mode && !rst_req && !expire && !kick)
      |=> count == $past(count) + 1'b1); // R5
endmodule

// File: tb/sim_svc_watchdog.sv
`timescale 1ns/1ps
module sim_svc_watchdog;
  localparam int W    = 10;
  localparam int LEN  = 6;
  localparam int FULL = 1 << W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       idle_mode = 1'b0;
  logic       pdown_mode = 1'b0;
  logic       rst_req;

  int checks = 0;
  int failures = 0;
  int ecount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) ecount++;

  svc_watchdog #(.CNT_W(W), .RST_LEN(LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
    .wr_data(wr_data), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
    .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mc_tick = 1'b1; wr_en = 1'b0; idle_mode = 1'b0; pdown_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset holds rst_req low", int'(rst_req), 0);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(output int at);
    int guard = 0;
    while (!rst_req && guard < 4 * FULL) begin
      @(negedge clk);
      guard++;
    end
    at = ecount;
  endtask

  task automatic wait_fall(output int at);
    int guard = 0;
    while (rst_req && guard < 4 * LEN + 4) begin
      @(negedge clk);
      guard++;
    end
    at = ecount;
  endtask

  task automatic t_expiry();
    int e0, er, ef, er2;
    do_reset();
    e0 = ecount;
    wait_rise(er);
    check("R3 expiry edges from reset", er - e0, FULL);
    wait_fall(ef);
    check("R7 pulse length", ef - er, LEN);
    wait_rise(er2);
    check("R7 restart from zero after pulse", er2 - ef, FULL);
  endtask

  task automatic t_kick();
    int e0, er;
    do_reset();
    idle_edges(300);
    wr(8'h1E);
    wr(8'hE1);
    e0 = ecount;
    wait_rise(er);
    check("R2 expiry edges after service", er - e0, FULL);
  endtask

  task automatic t_gap_and_repeat();
    int e0, er;
    do_reset();
    idle_edges(200);
    wr(8'h1E);
    idle_edges(40);
    wr(8'hE1);
    e0 = ecount;
    idle_edges(300);
    wr(8'h1E);
    wr(8'h1E);
    wr(8'hE1);
    e0 = ecount;
    wait_rise(er);
    check("R4 gap then repeated first key still service", er - e0, FULL);
  endtask

  task automatic t_bad_keys();
    int e0, er;
    do_reset();
    e0 = ecount;
    idle_edges(100);
    wr(8'hE1);
    idle_edges(100);
    wr(8'h1E);
    wr(8'h55);
    wr(8'hE1);
    wr(8'h00);
    wr(8'hFF);
    wait_rise(er);
    check("R4 broken keys leave count unchanged", er - e0, FULL);
  endtask

  task automatic t_modes();
    int e0, er;
    do_reset();
    idle_mode = 1'b1;
    e0 = ecount;
    wait_rise(er);
    check("R5 idle keeps counting", er - e0, FULL);
    idle_mode = 1'b0;
    do_reset();
    e0 = ecount;
    idle_edges(100);
    pdown_mode = 1'b1;
    idle_edges(200);
    pdown_mode = 1'b0;
    wait_rise(er);
    check("R5 power-down freezes count", er - e0, FULL + 200);
  endtask

  task automatic t_tick_gate();
    int e0, er;
    do_reset();
    e0 = ecount;
    idle_edges(50);
    mc_tick = 1'b0;
    idle_edges(150);
    mc_tick = 1'b1;
    for (int i = 0; i < 60; i++) begin
      mc_tick = i[0];
      @(negedge clk);
    end
    mc_tick = 1'b1;
    wait_rise(er);
    check("R6 no advance without tick", er - e0, FULL + 150 + 30);
  endtask

  task automatic t_write_in_pulse();
    int er, ef, er2;
    do_reset();
    wait_rise(er);
    check("R7 pulse is high before write", int'(rst_req), 1);
    wr(8'h1E);
    wait_fall(ef);
    idle_edges(100);
    wr(8'hE1);
    wait_rise(er2);
    check("R7 write during pulse ignored", er2 - ef, FULL);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_expiry();
    t_kick();
    t_gap_and_repeat();
    t_bad_keys();
    t_modes();
    t_tick_gate();
    t_write_in_pulse();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule